// File: doc/BRIEF.md
# Bit-Stuffing NRZI Line Encoder

This block turns a bit-serial packet stream into inverted non-return-to-zero line symbols on a differential pair. A source offers one bit at a time with valid/ready and marks the first and last bit of every packet. At each bit time the encoder either takes the offered bit, or it sends a stuffed zero that it inserted itself. Every zero toggles the line and every one leaves it where it is. A receiver recovers its clock from the edges, so a run of ones never grows longer than six without an edge.

The bit time comes from an internal clock divider. It has a slow rate and a fast rate, chosen by a mode input that is sampled at each bit time. Between packets the pair rests in the idle (J) state: positive leg high, negative leg low. Each packet is encoded starting from that idle level.

Top module: `nrzi_stuff_tx`

## Requirements
- R1: While reset is held and after it is released, dp_o is 1 and dn_o is 0 (J) until a bit is sent.
- R2: A data bit of 0 sent at a bit time toggles dp_o after that bit time.
- R3: A data bit of 1 sent at a bit time leaves dp_o unchanged.
- R4: The run counter counts accepted data ones. A data zero, a stuffed zero and a bit flagged as packet start each restart it. When it reaches six, the next bit time sends a stuffed zero, which toggles the line, and accepts no input.
- R5: in_ready_o is high for exactly one clock per bit time, except when a stuffed zero is due. A bit transfers when in_valid_i and in_ready_o are both high on a clock edge.
- R6: When the sixth consecutive one is the bit flagged in_eop_i, a stuffed zero still follows it before the packet ends.
- R7: A bit flagged in_sop_i is encoded against the J level (dp_o = 1), whatever level the line holds at that moment.
- R8: At a bit time with nothing to send, the line returns to J if no packet is open. If a packet is open, the line holds its level. A packet closes after its in_eop_i bit and any stuffed zero that follows it.
- R9: dn_o is always the complement of dp_o.
- R10: The first bit time is the first clock after reset. Each later bit time comes LS_DIV clocks after the previous one when fast_i was 0 at that previous bit time, and FS_DIV clocks after it when fast_i was 1. dp_o changes only at the clock edge that ends a bit time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fast_i | input | 1 | Bit-rate select: 1 = fast divider, 0 = slow divider |
| in_valid_i | input | 1 | Source offers a bit |
| in_data_i | input | 1 | Offered data bit |
| in_sop_i | input | 1 | Offered bit is the first bit of a packet |
| in_eop_i | input | 1 | Offered bit is the last bit of a packet |
| in_ready_o | output | 1 | Encoder takes the offered bit on this clock |
| dp_o | output | 1 | Positive leg of the differential line |
| dn_o | output | 1 | Negative leg, the complement of dp_o |

## Verification
The bench builds the encoder with LS_DIV = 5 and FS_DIV = 2. Bit times are therefore a few clocks long, and both rates run in the same test with mode changes between packets. This lets long runs of ones, repeated stuffing inside one packet, stuffing on the last bit, back-to-back packets that end on K, and mid-packet source stalls all fit within a few thousand clocks. The default STUFF_RUN of six is kept, so the stuffing threshold under test is the real one.

// File: rtl/nrzi_tx_pkg.sv
package nrzi_tx_pkg;
  localparam logic LINE_J = 1'b1;

  typedef struct packed {
    logic vld;    // a symbol goes out this bit time
    logic val;    // symbol value before NRZI
    logic first;  // symbol opens a packet
  } sym_t;
endpackage

// File: rtl/nrzi_bit_timer.sv
module nrzi_bit_timer #(
  parameter int LS_DIV = 32,
  parameter int FS_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fast_i,
  output logic tick_o
);
  localparam int MAX_DIV = (LS_DIV > FS_DIV) ? LS_DIV : FS_DIV;
  localparam int CNT_W   = $clog2(MAX_DIV);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= fast_i ? CNT_W'(FS_DIV - 1) : CNT_W'(LS_DIV - 1);
    else             cnt_q <= cnt_q - 1'b1;
  end

  // R10: bit times never fall on adjacent clocks (both dividers >= 2)
  a_r10_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/nrzi_bit_stuffer.sv
module nrzi_bit_stuffer
  import nrzi_tx_pkg::*;
#(
  parameter int STUFF_RUN = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic in_valid_i,
  input  logic in_data_i,
  input  logic in_sop_i,
  input  logic in_eop_i,
  output logic in_ready_o,
  output sym_t sym_o,
  output logic pkt_open_o
);
  localparam int CW = $clog2(STUFF_RUN + 1);

  logic [CW-1:0] ones_q, run_base, run_nxt;
  logic          stuff_q, open_q, last_q;
  logic          accept, hit;

  assign in_ready_o = tick_i && !stuff_q;
  assign accept     = in_valid_i && in_ready_o;
  assign run_base   = in_sop_i ? '0 : ones_q;
  assign run_nxt    = in_data_i ? run_base + 1'b1 : '0;
  assign hit        = in_data_i && (run_nxt == CW'(STUFF_RUN));

  assign sym_o.vld   = accept || (tick_i && stuff_q);
  assign sym_o.val   = stuff_q ? 1'b0 : in_data_i;
  assign sym_o.first = !stuff_q && in_sop_i;
  assign pkt_open_o  = open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q  <= '0;
      stuff_q <= 1'b0;
      open_q  <= 1'b0;
      last_q  <= 1'b0;
    end else if (tick_i && stuff_q) begin
      ones_q  <= '0;
      stuff_q <= 1'b0;
      if (last_q) open_q <= 1'b0;
    end else if (accept) begin
      ones_q  <= run_nxt;
      stuff_q <= hit;
      last_q  <= in_eop_i;
      open_q  <= !in_eop_i || hit;  // stay open through a trailing stuffed bit
    end
  end

  a_r4_run_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ones_q < CW'(STUFF_RUN)) || stuff_q);

  a_r4_stall_one_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stuff_q && tick_i) |=> !stuff_q);
endmodule

// File: rtl/nrzi_line_enc.sv
module nrzi_line_enc
  import nrzi_tx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  sym_t sym_i,
  input  logic pkt_open_i,
  output logic line_o
);
  logic line_q, base;

  assign base   = sym_i.first ? LINE_J : line_q;
  assign line_o = line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   line_q <= LINE_J;
    else if (sym_i.vld)            line_q <= sym_i.val ? base : ~base;
    else if (tick_i && !pkt_open_i) line_q <= LINE_J;
  end

  a_r2_zero_toggles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_i.vld && !sym_i.val && !sym_i.first) |=> (line_q != $past(line_q)));

  a_r3_one_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_i.vld && sym_i.val && !sym_i.first) |=> (line_q == $past(line_q)));

  a_r7_sop_from_j: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_i.vld && sym_i.first && sym_i.val) |=> (line_q == LINE_J));
endmodule

// File: rtl/nrzi_stuff_tx.sv
module nrzi_stuff_tx
  import nrzi_tx_pkg::*;
#(
  parameter int LS_DIV    = 32,
  parameter int FS_DIV    = 4,
  parameter int STUFF_RUN = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fast_i,
  input  logic in_valid_i,
  input  logic in_data_i,
  input  logic in_sop_i,
  input  logic in_eop_i,
  output logic in_ready_o,
  output logic dp_o,
  output logic dn_o
);
  logic tick, pkt_open, line;
  sym_t sym;

  nrzi_bit_timer #(.LS_DIV(LS_DIV), .FS_DIV(FS_DIV)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .fast_i(fast_i), .tick_o(tick)
  );

  nrzi_bit_stuffer #(.STUFF_RUN(STUFF_RUN)) u_stuff (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i),
    .in_sop_i(in_sop_i), .in_eop_i(in_eop_i),
    .in_ready_o(in_ready_o), .sym_o(sym), .pkt_open_o(pkt_open)
  );

  nrzi_line_enc u_enc (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .sym_i(sym), .pkt_open_i(pkt_open), .line_o(line)
  );

  assign dp_o = line;
  assign dn_o = ~line;

  a_r10_line_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(dp_o));

  a_r5_ready_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |=> !in_ready_o);
endmodule

// File: tb/tb_nrzi_stuff_tx.sv
module tb_nrzi_stuff_tx;
  localparam int LS = 5;
  localparam int FS = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic fast_i = 1'b0;
  logic in_valid_i = 1'b0, in_data_i = 1'b0, in_sop_i = 1'b0, in_eop_i = 1'b0;
  logic in_ready_o, dp_o, dn_o;

  nrzi_stuff_tx #(.LS_DIV(LS), .FS_DIV(FS), .STUFF_RUN(6)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .fast_i(fast_i),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i),
    .in_sop_i(in_sop_i), .in_eop_i(in_eop_i),
    .in_ready_o(in_ready_o), .dp_o(dp_o), .dn_o(dn_o)
  );

  always #4 clk = ~clk;  // 125 MHz

  int n_run = 0, n_fail = 0;
  bit done = 1'b0, first_chk = 1'b1, allow_stall = 1'b0, fast_sel = 1'b0;
  logic [2:0] q[$];  // {sop, eop, data}

  // bench expectation state
  int   m_cnt = 0, m_ones = 0;
  logic m_line = 1'b1, m_stuff = 1'b0, m_open = 1'b0, m_last = 1'b0;
  string m_tag = "R1";

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push_pkt(input int len, input logic [31:0] bits);
    for (int i = 0; i < len; i++)
      q.push_back({(i == 0), (i == len - 1), bits[i]});
  endtask

  task automatic drain(input int gap);
    while (q.size() != 0 || m_open) @(negedge clk);
    repeat (gap) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      logic tk, rdy, acc, base;
      int run;
      if (first_chk) begin
        chk("R1", dp_o, 1'b1);
        chk("R1", dn_o, 1'b0);
        first_chk = 1'b0;
      end
      chk(m_tag, dp_o, m_line);
      chk("R9", dn_o, ~dp_o);
      rdy = (m_cnt == 0) && !m_stuff;
      chk("R5", in_ready_o, rdy);

      // drive the inputs seen at the next rising edge
      fast_i = fast_sel;
      if (q.size() != 0 && !(allow_stall && m_open && ($urandom % 6 == 0))) begin
        in_valid_i = 1'b1;
        {in_sop_i, in_eop_i, in_data_i} = q[0];
      end else begin
        in_valid_i = 1'b0;
        {in_sop_i, in_eop_i, in_data_i} = 3'b000;
      end

      // expected effect of that edge
      tk  = (m_cnt == 0);
      acc = in_valid_i && rdy;
      if (tk) m_cnt = fast_i ? FS - 1 : LS - 1;
      else    m_cnt = m_cnt - 1;
      if (tk && m_stuff) begin
        m_line = ~m_line; m_stuff = 1'b0; m_ones = 0;
        m_tag = m_last ? "R6" : "R4";
        if (m_last) m_open = 1'b0;
      end else if (acc) begin
        base   = in_sop_i ? 1'b1 : m_line;
        m_line = in_data_i ? base : ~base;
        run    = in_sop_i ? 0 : m_ones;
        run    = in_data_i ? run + 1 : 0;
        m_ones = run;
        m_stuff = (run == 6);
        m_last = in_eop_i;
        m_open = !in_eop_i || m_stuff;
        m_tag  = in_sop_i ? "R7" : (in_data_i ? "R3" : "R2");
        void'(q.pop_front());
      end else if (tk) begin
        if (!m_open) m_line = 1'b1;
        m_tag = "R8";
      end else begin
        m_tag = "R10";
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    chk("R1", dp_o, 1'b1);  // during reset
    chk("R1", dn_o, 1'b0);
    #1 rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    // directed corners
    push_pkt(8, 32'h00);          // all zeros: toggle each bit (R2)
    drain(4);
    push_pkt(8, 32'h7F);          // seven ones: stuff mid packet (R4)
    drain(7);
    push_pkt(6, 32'h3F);          // sixth one is the last bit (R6)
    drain(3);
    fast_sel = 1'b1;
    push_pkt(12, 32'hFFF);        // two stuffed bits (R4)
    drain(5);
    push_pkt(12, 32'hFDF);        // zero restarts the run
    drain(2);
    push_pkt(3, 32'h6);           // ends on K, next packet back to back (R7)
    push_pkt(5, 32'h1F);          // run restarts at sop: no stuff
    drain(0);
    fast_sel = 1'b0;
    push_pkt(4, 32'hE);
    drain(0);
    // random packets, ones-heavy, with source stalls
    allow_stall = 1'b1;
    for (int p = 0; p < 40; p++) begin
      fast_sel = ($urandom % 2) == 1;
      push_pkt(1 + $urandom % 24, $urandom | $urandom);
      drain($urandom % 12);
    end
    drain(10);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL R10 watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule